// File: doc/BRIEF.md
# Indirect Byte-Register Access Port

This block sits between a host register interface and a bank of 8-bit internal registers addressed by a 14-bit index. The host sees a single 32-bit mailbox word. A request is placed by writing that word with its busy flag set. The word carries the direction, the target index, a bit mask and a data byte. The port then carries out the access against the internal bank on its own and drops the busy flag when it has finished. After that, the low byte of the same word holds the outcome. For a read, this is the value that was fetched. For a write, it is the value the register holds after the write, so software can compare it with what it asked for.

Every access runs the same three-phase sequence. In the fetch phase the register's current value is captured. In the store phase a masked merge is written back, and only for a write. In the check phase the register is read once more to produce the result byte. Every request therefore finishes a fixed three cycles after it is captured. This is far inside the polling budget that software allows. While a request is in flight the word is frozen, and further host writes have no effect.

Top module: `byte_window_port`

## Requirements
- R1: After reset the mailbox word reads as all zeros, and neither the internal read strobe nor the internal write strobe is asserted.
- R2: The mailbox word layout is: bit 31 busy, bit 30 write flag (1 = write, 0 = read), bits 29:16 target index, bits 15:8 mask, bits 7:0 data/result. A host write with bit 31 set while busy is clear starts an access, and the written word reads back with busy set on the next cycle.
- R3: Busy stays set for exactly three cycles after the clock edge that captures the request, then clears.
- R4: A read request leaves bits 30:8 as written, returns the addressed register's value in bits 7:0, and issues no internal write.
- R5: A write request changes only the register bits whose mask bit is 1. A zero mask leaves the register unchanged, and a mask of 0xFF replaces it entirely.
- R6: When a write request completes, bits 7:0 hold the register's value as read back after the write, and bits 30:8 are kept.
- R7: Host writes that arrive while busy is set are ignored: they alter neither the word nor any internal register.
- R8: A host write with bit 31 clear while idle is ignored: the word is unchanged and no internal access is made.
- R9: Every internal read or write strobe presents the request's target index on the internal address port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host write strobe for the mailbox word |
| host_wdata | input | 32 | Host write data (request word) |
| host_rdata | output | 32 | Current mailbox word (busy, request fields, result) |
| rf_addr | output | 14 | Internal register index |
| rf_rd | output | 1 | Internal read strobe |
| rf_rdata | input | 8 | Internal register value for rf_addr, combinational |
| rf_wr | output | 1 | Internal write strobe |
| rf_wdata | output | 8 | Internal write data (masked merge) |

## Verification
The main function is tried with reads of registers preloaded with distinct values, and with writes whose masks are zero, all ones and mixed. The zero mask separates a port that writes the data blindly from one that merges it. The mixed mask shows which side of the merge each bit is taken from. A read issued after each write shows whether the write result byte really matches the register contents. Indices that differ in their high bits show whether the full index field reaches the internal port. Host writes issued in mid-flight, and idle writes with busy clear, are checked against the result word and the internal write count, so a port that accepts them is caught.

// File: rtl/bwp_pkg.sv
package bwp_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_FETCH = 2'd1,
      PH_STORE = 2'd2,
      PH_CHECK = 2'd3
   } phase_t;
endpackage

// File: rtl/bwp_merge.sv
module bwp_merge #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] old_bits,
   input  logic [DATA_W-1:0] sel_mask,
   input  logic [DATA_W-1:0] new_bits,
   output logic [DATA_W-1:0] merged
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("bwp_merge: DATA_W must be positive");
      end
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         assign merged[b] = sel_mask[b] ? new_bits[b] : old_bits[b];
      end
   endgenerate
endmodule

// File: rtl/bwp_seq.sv
module bwp_seq
   import bwp_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   output phase_t phase
);
   phase_t phase_d;

   always_comb begin
      phase_d = phase;
      case (phase)
         PH_IDLE:  if (start) phase_d = PH_FETCH;
         PH_FETCH: phase_d = PH_STORE;
         PH_STORE: phase_d = PH_CHECK;
         PH_CHECK: phase_d = PH_IDLE;
         default:  phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= PH_IDLE;
      else        phase <= phase_d;
   end

   // R3: the three phases follow each other without stalls
   p_phase_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_FETCH) |=> (phase == PH_STORE));
   p_phase_check_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_STORE) |=> (phase == PH_CHECK));
endmodule

// File: rtl/byte_window_port.sv
module byte_window_port
   import bwp_pkg::*;
#(
   parameter int ADDR_W        = 14,
   parameter int DATA_W        = 8,
   parameter int WORD_W        = 32,
   parameter int VERIFY_RDBACK = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [WORD_W-1:0] host_wdata,
   output logic [WORD_W-1:0] host_rdata,
   output logic [ADDR_W-1:0] rf_addr,
   output logic              rf_rd,
   input  logic [DATA_W-1:0] rf_rdata,
   output logic              rf_wr,
   output logic [DATA_W-1:0] rf_wdata
);
   localparam int BUSY_B  = WORD_W - 1;
   localparam int WRITE_B = WORD_W - 2;
   localparam int ADDR_LO = 2 * DATA_W;
   localparam int MASK_LO = DATA_W;
   localparam int KEEP_W  = WORD_W - 1 - DATA_W;

   generate
      if (WORD_W != ADDR_W + 2 * DATA_W + 2) begin : g_bad_layout
         $error("byte_window_port: WORD_W must equal ADDR_W + 2*DATA_W + 2");
      end
      if (VERIFY_RDBACK != 0 && VERIFY_RDBACK != 1) begin : g_bad_mode
         $error("byte_window_port: VERIFY_RDBACK must be 0 or 1");
      end
   endgenerate

   logic [WORD_W-1:0] word_q;
   logic [DATA_W-1:0] old_q;
   logic [DATA_W-1:0] merged;
   logic [DATA_W-1:0] wr_val;
   logic [DATA_W-1:0] result;
   logic              rd_in_check;
   logic              start;
   logic              busy;
   logic              wr_flag;
   logic [DATA_W-1:0] req_mask;
   logic [DATA_W-1:0] req_data;
   phase_t            phase;

   assign busy     = word_q[BUSY_B];
   assign wr_flag  = word_q[WRITE_B];
   assign req_mask = word_q[MASK_LO +: DATA_W];
   assign req_data = word_q[DATA_W-1:0];
   assign start    = host_wr && host_wdata[BUSY_B] && (phase == PH_IDLE);

   bwp_seq u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .phase (phase)
   );

   bwp_merge #(.DATA_W(DATA_W)) u_merge (
      .old_bits (old_q),
      .sel_mask (req_mask),
      .new_bits (req_data),
      .merged   (merged)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  old_q <= '0;
      else if (phase == PH_FETCH)  old_q <= rf_rdata;
   end

   assign wr_val = wr_flag ? merged : old_q;

   generate
      if (VERIFY_RDBACK == 1) begin : g_readback
         assign result      = rf_rdata;
         assign rd_in_check = 1'b1;
      end else begin : g_computed
         assign result      = wr_val;
         assign rd_in_check = 1'b0;
      end
   endgenerate

   assign rf_addr  = word_q[ADDR_LO +: ADDR_W];
   assign rf_rd    = (phase == PH_FETCH) || ((phase == PH_CHECK) && rd_in_check);
   assign rf_wr    = (phase == PH_STORE) && wr_flag;
   assign rf_wdata = merged;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 word_q <= '0;
      else if (start)             word_q <= host_wdata;
      else if (phase == PH_CHECK) word_q <= {1'b0, word_q[WRITE_B -: KEEP_W], result};
   end

   assign host_rdata = word_q;

   // R2: the busy bit in the word tracks the sequencer being active
   p_busy_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy == (phase != PH_IDLE));

   // R3: busy lasts exactly three cycles
   p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> busy ##1 busy ##1 !busy);

   // R4: a read request never strobes an internal write
   p_read_no_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !wr_flag) |-> !rf_wr);

   // R5: bits outside the mask keep the register's present value
   p_keep_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wr |-> (((rf_wdata ^ rf_rdata) & ~req_mask) == '0));

   // R7: the request fields stay frozen while busy
   p_hold_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(word_q[WRITE_B:DATA_W]));

   // R9: at most one internal strobe at a time, only while busy
   p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rf_rd, rf_wr}) && ((rf_rd || rf_wr) -> busy));
endmodule

// File: tb/byte_window_port_tb_top.sv
module byte_window_port_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic [13:0] rf_addr;
   logic        rf_rd;
   logic [7:0]  rf_rdata;
   logic        rf_wr;
   logic [7:0]  rf_wdata;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   byte_window_port dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (host_wr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .rf_addr    (rf_addr),
      .rf_rd      (rf_rd),
      .rf_rdata   (rf_rdata),
      .rf_wr      (rf_wr),
      .rf_wdata   (rf_wdata)
   );

   // internal register bank model, indexed by the low index byte
   logic [7:0]  bank [0:255];
   logic [13:0] last_wr_addr;
   int          wr_cnt;
   logic [7:0]  shadow [0:255];

   function automatic logic [7:0] seed(int i);
      return 8'((i * 37 + 5) & 255);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) bank[i] <= seed(i);
         wr_cnt       <= 0;
         last_wr_addr <= '0;
      end else if (rf_wr) begin
         bank[rf_addr[7:0]] <= rf_wdata;
         wr_cnt             <= wr_cnt + 1;
         last_wr_addr       <= rf_addr;
      end
   end
   assign rf_rdata = bank[rf_addr[7:0]];

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   // scoreboard queues
   logic [31:0] exp_q [$];
   string       tag_q [$];

   // monitor: pops at each busy falling edge, checks word and latency
   logic prev_busy = 1'b0;
   int   busy_cnt  = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (host_rdata[31]) begin
            busy_cnt++;
         end else if (prev_busy) begin
            if (exp_q.size() > 0) begin
               logic [31:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(t, host_rdata, e);
               check("R3", 32'(busy_cnt), 32'd3);
            end else begin
               check("R7", 32'hFFFF_FFFF, 32'h0);
            end
            busy_cnt = 0;
         end
         prev_busy = host_rdata[31];
      end
   end

   task automatic do_req(input logic wr, input logic [13:0] addr,
                         input logic [7:0] mask, input logic [7:0] data,
                         input string tag, input logic intrude);
      logic [7:0] cur, nv;
      cur = shadow[addr[7:0]];
      nv  = wr ? ((cur & ~mask) | (data & mask)) : cur;
      shadow[addr[7:0]] = nv;
      exp_q.push_back({1'b0, wr, addr, mask, nv});
      tag_q.push_back(tag);
      @(negedge clk);
      host_wr    = 1'b1;
      host_wdata = {1'b1, wr, addr, mask, data};
      @(negedge clk);
      host_wr = 1'b0;
      check("R2", 32'(host_rdata[31]), 32'd1);
      if (intrude) begin
         host_wr    = 1'b1;
         host_wdata = {1'b1, 1'b1, addr ^ 14'h0005, 8'hFF, ~data};
         @(negedge clk);
         host_wr = 1'b0;
      end
      for (int p = 0; p < 1024; p++) begin
         if (!host_rdata[31]) break;
         @(negedge clk);
      end
      @(negedge clk);
   endtask

   task automatic finish_up;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      int wc;
      logic [31:0] snap;
      for (int i = 0; i < 256; i++) shadow[i] = seed(i);
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", host_rdata, 32'h0);
      check("R1", {30'd0, rf_rd, rf_wr}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: plain reads with no internal write
      wc = wr_cnt;
      do_req(1'b0, 14'h0012, 8'h00, 8'h00, "R4", 1'b0);
      do_req(1'b0, 14'h3F77, 8'hA5, 8'h3C, "R4", 1'b0);
      check("R4", 32'(wr_cnt), 32'(wc));

      // R5: full mask, zero mask, mixed mask; R6 result byte
      do_req(1'b1, 14'h0020, 8'hFF, 8'h5A, "R6", 1'b0);
      check("R9", 32'(last_wr_addr), 32'h0020);
      do_req(1'b1, 14'h2A31, 8'h00, 8'hFF, "R5", 1'b0);
      check("R9", 32'(last_wr_addr), 32'h2A31);
      do_req(1'b1, 14'h1540, 8'hF0, 8'h96, "R5", 1'b0);
      check("R9", 32'(last_wr_addr), 32'h1540);
      do_req(1'b1, 14'h0051, 8'h3C, 8'hC3, "R5", 1'b0);
      // read-back of written registers
      do_req(1'b0, 14'h0020, 8'h00, 8'h00, "R6", 1'b0);
      do_req(1'b0, 14'h1540, 8'h00, 8'h00, "R5", 1'b0);
      do_req(1'b0, 14'h2A31, 8'h00, 8'h00, "R5", 1'b0);

      // R7: host write while busy is ignored
      wc = wr_cnt;
      do_req(1'b1, 14'h0060, 8'h0F, 8'hE1, "R7", 1'b1);
      check("R7", 32'(wr_cnt), 32'(wc + 1));
      do_req(1'b0, 14'h0065, 8'h00, 8'h00, "R7", 1'b0);
      do_req(1'b0, 14'h0060, 8'h00, 8'h00, "R7", 1'b0);

      // R8: idle write with busy clear is ignored
      snap = host_rdata;
      wc   = wr_cnt;
      @(negedge clk);
      host_wr    = 1'b1;
      host_wdata = {1'b0, 1'b1, 14'h0070, 8'hFF, 8'h11};
      @(negedge clk);
      host_wr = 1'b0;
      repeat (4) @(negedge clk);
      check("R8", host_rdata, snap);
      check("R8", 32'(wr_cnt), 32'(wc));
      do_req(1'b0, 14'h0070, 8'h00, 8'h00, "R8", 1'b0);

      repeat (2) @(negedge clk);
      check("R3", 32'(exp_q.size()), 32'd0);
      finish_up();
   end
endmodule